// File: doc/BRIEF.md
# Staggered-Phase Sampling Storage Bit

This block holds one data bit in a way that tolerates radiation-induced transients. Three independent capture pairs watch the same data input. Each pair is a lead latch followed by a trail latch, and each pair is opened by its own phase enable. Because the three phases are offset in time, the pairs sample the bit at three separate moments. A short glitch on the data line, or a spurious pulse on one phase line, can therefore spoil the capture of only one pair.

All six latch outputs leave the block as individual nodes, so that a downstream weighted voter can resolve the stored value. The block is modelled synchronously. A fast system clock drives every storage element. Each latch is "transparent" on the fast-clock edges where its enable is active and holds its value on all other edges. A lead latch is open while its phase enable is high. The trail latch of the same pair is open while that phase enable is low. Each pair therefore behaves as a flip-flop that captures on the falling edge of its phase.

A per-node inversion mask lets a test environment upset any node for as long as the mask bit is held, typically one fast-clock cycle. This is used to exercise the voter and the propagation of upsets.

Top module: `temporal_sampling_stage`

## Requirements
- R1: While `rst_n` is low, every latch is cleared, and `node` equals `inj_mask` (all stored values are zero).
- R2: On every fast-clock rising edge where `phase_en[k]` is 1, the lead latch of pair k loads `din`. The lead latch drives node bit 2k, so bit 0 is pair 0's lead, bit 2 is pair 1's lead and bit 4 is pair 2's lead.
- R3: On every edge where `phase_en[k]` is 0, the stored value of pair k's lead latch is unchanged.
- R4: On every edge where `phase_en[k]` is 1, the stored value of pair k's trail latch is unchanged. The trail latch drives node bit 2k+1.
- R5: On every edge where `phase_en[k]` is 0, pair k's trail latch loads the visible lead node `node[2k]`. After a phase falls, the captured bit appears on the trail node one fast-clock cycle later.
- R6: The phase enable of one pair has no effect on the nodes of the other pairs.
- R7: Bit i of `inj_mask` inverts `node[i]` combinationally while that bit is set, without altering any stored value. Once the bit is cleared, the node shows its stored value again.
- R8: An inversion on a lead node that is held across an edge where the same pair's trail latch is open is captured by that trail latch. An inversion applied while the trail latch is closed leaves the trail latch unchanged.
- R9: A data glitch lasting one fast-clock cycle, during which only one phase enable is high, corrupts only that pair's two nodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; all latches update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the environment |
| din | input | 1 | Data bit sampled by all three pairs |
| phase_en | input | NUM_PAIRS | Phase enables; bit k opens pair k's lead latch (high) or trail latch (low) |
| inj_mask | input | 2*NUM_PAIRS | Per-node inversion mask for upset injection |
| node | output | 2*NUM_PAIRS | Latch outputs; bit 2k is lead of pair k, bit 2k+1 is trail of pair k |

## Verification
The hardest case to reach from the ports is an upset that travels from a lead node into its trail latch. This case needs the lead latch closed and the trail latch open on the very edge where the inversion is held. The stimulus drives all phases low, holds a single lead mask bit across exactly one edge, and then shows that the trail node has taken the inverted value and recovers one cycle after the mask is removed. A one-cycle data glitch with only the middle phase open is used to show that the corruption stays confined to a single pair while the other two carry the correct bit.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int unsigned DEFAULT_PAIRS = 3;
  localparam int unsigned NODES_PER_PAIR = 2;

  function automatic int unsigned lead_idx(input int unsigned k);
    return NODES_PER_PAIR * k;
  endfunction

  function automatic int unsigned trail_idx(input int unsigned k);
    return NODES_PER_PAIR * k + 1;
  endfunction
endpackage

// File: rtl/tsl_latch_cell.sv
module tsl_latch_cell #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (open_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/tsl_phase_pair.sv
module tsl_phase_pair #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phase_i,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] flip_lead_i,
  input  logic [W-1:0] flip_trail_i,
  output logic [W-1:0] lead_o,
  output logic [W-1:0] trail_o
);
  logic [W-1:0] lead_q;
  logic [W-1:0] trail_q;
  logic [W-1:0] lead_seen;
  logic         trail_open;

  assign trail_open = ~phase_i;

  tsl_latch_cell #(.W(W)) u_lead (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (phase_i),
    .d_i    (d_i),
    .q_o    (lead_q)
  );

  // Upset on the lead node is what the trail latch sees.
  assign lead_seen = lead_q ^ flip_lead_i;

  tsl_latch_cell #(.W(W)) u_trail (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (trail_open),
    .d_i    (lead_seen),
    .q_o    (trail_q)
  );

  assign lead_o  = lead_seen;
  assign trail_o = trail_q ^ flip_trail_i;
endmodule

// File: rtl/temporal_sampling_stage.sv
module temporal_sampling_stage
  import tsl_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = DEFAULT_PAIRS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                din,
  input  logic [NUM_PAIRS-1:0]                phase_en,
  input  logic [NODES_PER_PAIR*NUM_PAIRS-1:0] inj_mask,
  output logic [NODES_PER_PAIR*NUM_PAIRS-1:0] node
);
  localparam int unsigned NODE_W = NODES_PER_PAIR * NUM_PAIRS;

  logic [NODE_W-1:0] node_w;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    localparam int unsigned LI = lead_idx(k);
    localparam int unsigned TI = trail_idx(k);

    tsl_phase_pair #(.W(1)) u_pair (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase_i      (phase_en[k]),
      .d_i          (din),
      .flip_lead_i  (inj_mask[LI]),
      .flip_trail_i (inj_mask[TI]),
      .lead_o       (node_w[LI]),
      .trail_o      (node_w[TI])
    );
  end

  assign node = node_w;
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker
  import tsl_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = DEFAULT_PAIRS
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                din,
  input logic [NUM_PAIRS-1:0]                phase_en,
  input logic [NODES_PER_PAIR*NUM_PAIRS-1:0] inj_mask,
  input logic [NODES_PER_PAIR*NUM_PAIRS-1:0] node
);
  localparam int unsigned NODE_W = NODES_PER_PAIR * NUM_PAIRS;

  logic [NODE_W-1:0] stored;
  assign stored = node ^ inj_mask;

  // R1: stored state is zero under reset
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_clear: assert (stored == '0);
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_chk
    localparam int unsigned LI = lead_idx(k);
    localparam int unsigned TI = trail_idx(k);

    a_r2_lead_loads: assert property (@(posedge clk) disable iff (!rst_n)
      phase_en[k] |=> stored[LI] == $past(din));

    a_r3_lead_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_en[k] |=> stored[LI] == $past(stored[LI]));

    a_r4_trail_holds: assert property (@(posedge clk) disable iff (!rst_n)
      phase_en[k] |=> stored[TI] == $past(stored[TI]));

    a_r5_trail_takes_lead: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_en[k] |=> stored[TI] == $past(node[LI]));
  end
endmodule

bind temporal_sampling_stage tsl_checker #(.NUM_PAIRS(NUM_PAIRS)) u_tsl_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .din      (din),
  .phase_en (phase_en),
  .inj_mask (inj_mask),
  .node     (node)
);

// File: tb/temporal_sampling_stage_bench.sv
module temporal_sampling_stage_bench;
  logic       clk;
  logic       rst_n;
  logic       din;
  logic [2:0] phase_en;
  logic [5:0] inj_mask;
  logic [5:0] node;

  int n_checks;
  int n_fail;

  temporal_sampling_stage #(.NUM_PAIRS(3)) u_temporal_sampling_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .phase_en (phase_en),
    .inj_mask (inj_mask),
    .node     (node)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Drive at a falling edge, step to the next falling edge.
  task automatic cyc(input logic d, input logic [2:0] p, input logic [5:0] m);
    din = d; phase_en = p; inj_mask = m;
    @(negedge clk);
  endtask

  task automatic chk(input logic [5:0] exp, input string req);
    n_checks++;
    if (node !== exp) begin
      n_fail++;
      $display("FAIL %s: node=%b expected=%b", req, node, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(1'b1, 3'b111, 6'b0);
    cyc(1'b1, 3'b111, 6'b0);
    chk(6'b000000, "R1");
    rst_n = 1'b1;
  endtask

  task automatic t_single_pair();
    do_reset();
    cyc(1'b1, 3'b001, 6'b0);
    chk(6'b000001, "R2/R4");
    cyc(1'b0, 3'b000, 6'b0);
    chk(6'b000011, "R3/R5");
    cyc(1'b0, 3'b000, 6'b0);
    chk(6'b000011, "R3");
  endtask

  task automatic t_staggered();
    do_reset();
    cyc(1'b1, 3'b001, 6'b0);
    chk(6'b000001, "R6");
    cyc(1'b1, 3'b010, 6'b0);
    chk(6'b000111, "R5/R6");
    cyc(1'b1, 3'b100, 6'b0);
    chk(6'b011111, "R2/R5");
    cyc(1'b0, 3'b000, 6'b0);
    chk(6'b111111, "R5");
  endtask

  task automatic t_glitch();
    cyc(1'b0, 3'b010, 6'b0);
    chk(6'b111011, "R9");
    cyc(1'b1, 3'b000, 6'b0);
    chk(6'b110011, "R9");
  endtask

  task automatic t_inject_view();
    cyc(1'b1, 3'b111, 6'b100001);
    chk(6'b010110, "R7");
    cyc(1'b1, 3'b111, 6'b0);
    chk(6'b110111, "R7");
  endtask

  task automatic t_inject_propagate();
    cyc(1'b1, 3'b000, 6'b000001);
    chk(6'b111100, "R8");
    cyc(1'b1, 3'b000, 6'b0);
    chk(6'b111111, "R8");
    cyc(1'b1, 3'b001, 6'b000001);
    chk(6'b111110, "R8/R4");
    cyc(1'b1, 3'b001, 6'b0);
    chk(6'b111111, "R8");
  endtask

  initial begin
    n_checks = 0; n_fail = 0;
    rst_n = 1'b1; din = 1'b0; phase_en = 3'b0; inj_mask = 6'b0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    t_single_pair();
    t_staggered();
    t_glitch();
    t_inject_view();
    t_inject_propagate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: node=%b expected=completion", node);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule